// File: doc/BRIEF.md
# Single-Bit Manipulation Execute Unit

This unit decodes and executes the four single-bit operations of the RISC-V bit-manipulation set: clear one bit, set one bit, flip one bit, and read one bit. The bit position comes from the low log2(XLEN) bits of operand B. A decoder turns that position into a one-hot mask. The chosen operation then combines the mask with operand A: AND with the inverted mask, OR, XOR, or an OR-reduction of A AND mask into bit 0.

The 32-bit instruction word is decoded in both its register form and its immediate form. Next to the result, the unit drives a 3-bit operation select, a 4-bit one-hot group flag, a valid flag, and the subtract/arithmetic control bit that the extract operation shares with subtract and arithmetic right shift. When `USE_REG` is set, these control outputs pass through a decode-to-execute register. That register has a synchronous reset, a flush and a stall, and the operands are then applied in the execute cycle. When `USE_REG` is clear, the whole unit is combinational.

Top module: `bitop_unit`

## Requirements
- R1: The mask has exactly one bit set: bit k is high when the low log2(XLEN) bits of `opb` equal k.
- R2: Clear (funct7 `010010x`, funct3 `001`) gives `opa & ~mask` with select `111`.
- R3: Set (funct7 `001010x`, funct3 `001`) gives `opa | mask` with select `110`.
- R4: Invert (funct7 `011010x`, funct3 `001`) gives `opa ^ mask` with select `100`.
- R5: Extract (funct7 `010010x`, funct3 `101`) gives bit 0 equal to `opa` at the index and all higher bits zero. Its select is `101` and `sub_arith` is high.
- R6: Opcode `0110011` (register form) and opcode `0010011` (immediate form) both decode, using the same function fields. Instruction bit 25, the lowest funct7 bit, is ignored for the register form at any XLEN and for the immediate form when XLEN is 64.
- R7: A decoded single-bit operation drives `op_valid` high and `op_class` to `0001`.
- R8: Any other instruction drives `op_sel` equal to instruction bits [14:12] and `op_class` to `0000`. It also drives `op_valid`, `sub_arith` and `result` to zero.
- R9: When XLEN is 32, an immediate-form instruction with bit 25 set is not decoded and follows R8.
- R10: With `USE_REG`, the control outputs reach the ports one clock after the instruction is presented, and `rst` clears them to zero.
- R11: With `USE_REG`, `flush` clears the register to zero at the next clock, even when `stall` is also high.
- R12: With `USE_REG`, `stall` without `flush` holds the registered control outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Clears the decode register |
| stall | input | 1 | Holds the decode register |
| instr | input | 32 | Instruction word |
| opa | input | XLEN | Operand A, the word being modified |
| opb | input | XLEN | Operand B, whose low bits give the index |
| result | output | XLEN | Operation result |
| op_sel | output | 3 | Operation select code |
| op_class | output | 4 | One-hot group flag, bit 0 for single-bit ops |
| op_valid | output | 1 | A single-bit operation is active |
| sub_arith | output | 1 | Subtract/arithmetic control bit, high for extract |

## Verification
The bench builds two copies of the unit. The first is XLEN 32 and purely combinational, so every index from 0 to 31 can be swept for all four operations in both forms against random A values. The rejection of immediate encodings with bit 25 set, which only exists at this width, is also within reach. The second is XLEN 64 with the decode register. It covers indices 32 to 63 reached through bit 25 of an immediate encoding, the one-cycle latency from instruction to execute, the reset value, flush priority over stall, and holding under stall.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam logic [2:0] SEL_CLR = 3'b111;
    localparam logic [2:0] SEL_SET = 3'b110;
    localparam logic [2:0] SEL_INV = 3'b100;
    localparam logic [2:0] SEL_EXT = 3'b101;

    localparam logic [3:0] CLS_SINGLE = 4'b0001;

    localparam logic [6:0] OPC_IMM = 7'b0010011;
    localparam logic [6:0] OPC_REG = 7'b0110011;

    localparam logic [5:0] F7H_CLR_EXT = 6'b010010;
    localparam logic [5:0] F7H_INV     = 6'b011010;
    localparam logic [5:0] F7H_SET     = 6'b001010;

    localparam logic [2:0] F3_EXT  = 3'b101;
    localparam logic [2:0] F3_MOD  = 3'b001;

    typedef struct packed {
        logic [2:0] sel;
        logic [3:0] cls;
        logic       valid;
        logic       arith;
    } bitop_ctrl_t;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [6:0]  opcode,
    input  logic [2:0]  funct3,
    input  logic [6:0]  funct7,
    output bitop_ctrl_t ctrl
);

    localparam bit WIDE = (XLEN > 32);

    logic form_ok;
    logic [5:0] f7h;

    always_comb begin
        f7h     = funct7[6:1];
        form_ok = (opcode == OPC_REG) ||
                  ((opcode == OPC_IMM) && (WIDE || !funct7[0]));

        ctrl.sel   = funct3;
        ctrl.cls   = 4'b0000;
        ctrl.valid = 1'b0;
        ctrl.arith = 1'b0;

        if (form_ok) begin
            if (f7h == F7H_CLR_EXT && funct3 == F3_MOD) begin
                ctrl.sel   = SEL_CLR;
                ctrl.valid = 1'b1;
            end else if (f7h == F7H_CLR_EXT && funct3 == F3_EXT) begin
                ctrl.sel   = SEL_EXT;
                ctrl.valid = 1'b1;
                ctrl.arith = 1'b1;
            end else if (f7h == F7H_SET && funct3 == F3_MOD) begin
                ctrl.sel   = SEL_SET;
                ctrl.valid = 1'b1;
            end else if (f7h == F7H_INV && funct3 == F3_MOD) begin
                ctrl.sel   = SEL_INV;
                ctrl.valid = 1'b1;
            end
        end

        if (ctrl.valid) begin
            ctrl.cls = CLS_SINGLE;
        end
    end

endmodule

// File: rtl/bitop_mask.sv
module bitop_mask #(
    parameter int XLEN = 32,
    parameter int IDXW = $clog2(XLEN)
) (
    input  logic [IDXW-1:0] idx,
    output logic [XLEN-1:0] mask
);

    for (genvar k = 0; k < XLEN; k++) begin : g_bit
        assign mask[k] = (idx == IDXW'(k));
    end

endmodule

// File: rtl/bitop_exec.sv
module bitop_exec
    import bitop_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  bitop_ctrl_t     ctrl,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] mask,
    output logic [XLEN-1:0] result
);

    always_comb begin
        result = '0;
        if (ctrl.valid) begin
            case (ctrl.sel)
                SEL_CLR: result = opa & ~mask;
                SEL_SET: result = opa | mask;
                SEL_INV: result = opa ^ mask;
                SEL_EXT: result = {{(XLEN-1){1'b0}}, |(opa & mask)};
                default: result = '0;
            endcase
        end
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter bit USE_REG = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            stall,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] result,
    output logic [2:0]      op_sel,
    output logic [3:0]      op_class,
    output logic            op_valid,
    output logic            sub_arith
);

    localparam int IDXW = $clog2(XLEN);

    bitop_ctrl_t     dec_ctrl;
    bitop_ctrl_t     exe_ctrl;
    logic [XLEN-1:0] mask;

    bitop_decode #(.XLEN(XLEN)) u_dec (
        .opcode (instr[6:0]),
        .funct3 (instr[14:12]),
        .funct7 (instr[31:25]),
        .ctrl   (dec_ctrl)
    );

    if (USE_REG) begin : g_reg
        bitop_ctrl_t ctrl_d;
        bitop_ctrl_t ctrl_q;

        always_comb begin
            if (flush) begin
                ctrl_d = '0;
            end else if (stall) begin
                ctrl_d = ctrl_q;
            end else begin
                ctrl_d = dec_ctrl;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q <= '0;
            end else begin
                ctrl_q <= ctrl_d;
            end
        end

        assign exe_ctrl = ctrl_q;

        AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
            flush |=> (ctrl_q == '0)); // R11
        AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (stall && !flush) |=> $stable(ctrl_q)); // R12
    end else begin : g_comb
        assign exe_ctrl = dec_ctrl;
    end

    bitop_mask #(.XLEN(XLEN), .IDXW(IDXW)) u_mask (
        .idx  (opb[IDXW-1:0]),
        .mask (mask)
    );

    bitop_exec #(.XLEN(XLEN)) u_exec (
        .ctrl   (exe_ctrl),
        .opa    (opa),
        .mask   (mask),
        .result (result)
    );

    assign op_sel    = exe_ctrl.sel;
    assign op_class  = exe_ctrl.cls;
    assign op_valid  = exe_ctrl.valid;
    assign sub_arith = exe_ctrl.arith;

    AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(mask) == 1); // R1
    AST_CLR_BITS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == SEL_CLR) |->
        ((result & mask) == '0 && (result | mask) == (opa | mask))); // R2
    AST_SET_BITS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == SEL_SET) |->
        ((result & mask) == mask && (result & ~mask) == (opa & ~mask))); // R3
    AST_INV_BITS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == SEL_INV) |-> ((result ^ opa) == mask)); // R4
    AST_EXT_UPPER: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == SEL_EXT) |->
        (result[XLEN-1:1] == '0 && sub_arith)); // R5
    AST_ARITH_ONLY_EXT: assert property (@(posedge clk) disable iff (rst)
        sub_arith |-> (op_valid && op_sel == SEL_EXT)); // R5
    AST_CLASS_VALID: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> (op_class == CLS_SINGLE)); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> (result == '0 && op_class == 4'b0000 && !sub_arith)); // R8

endmodule

// File: tb/sim_bitop_unit.sv
`timescale 1ns/1ps
module sim_bitop_unit;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // 32-bit combinational copy
    logic [31:0] instr0;
    logic [31:0] a0, b0, res0;
    logic [2:0]  sel0;
    logic [3:0]  cls0;
    logic        val0, ar0;

    // 64-bit registered copy
    logic        flush1 = 1'b0, stall1 = 1'b0;
    logic [31:0] instr1;
    logic [63:0] a1, b1, res1;
    logic [2:0]  sel1;
    logic [3:0]  cls1;
    logic        val1, ar1;

    bitop_unit #(.XLEN(32), .USE_REG(1'b0)) u0 (
        .clk(clk), .rst(rst), .flush(1'b0), .stall(1'b0),
        .instr(instr0), .opa(a0), .opb(b0), .result(res0),
        .op_sel(sel0), .op_class(cls0), .op_valid(val0), .sub_arith(ar0)
    );

    bitop_unit #(.XLEN(64), .USE_REG(1'b1)) u1 (
        .clk(clk), .rst(rst), .flush(flush1), .stall(stall1),
        .instr(instr1), .opa(a1), .opb(b1), .result(res1),
        .op_sel(sel1), .op_class(cls1), .op_valid(val1), .sub_arith(ar1)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // op: 0 clear, 1 set, 2 invert, 3 extract
    function automatic logic [31:0] enc(input int op, input bit imm,
                                        input bit b25, input logic [14:0] fill);
        logic [5:0] f7h;
        logic [2:0] f3;
        case (op)
            0: begin f7h = 6'b010010; f3 = 3'b001; end
            1: begin f7h = 6'b001010; f3 = 3'b001; end
            2: begin f7h = 6'b011010; f3 = 3'b001; end
            default: begin f7h = 6'b010010; f3 = 3'b101; end
        endcase
        return {f7h, b25, fill[4:0], fill[9:5], f3, fill[14:10],
                imm ? 7'b0010011 : 7'b0110011};
    endfunction

    function automatic logic [2:0] exp_sel(input int op);
        case (op)
            0: return 3'b111;
            1: return 3'b110;
            2: return 3'b100;
            default: return 3'b101;
        endcase
    endfunction

    function automatic logic [63:0] exp_res(input int op, input logic [63:0] a,
                                            input int idx, input int w);
        logic [63:0] m, r, wm;
        m  = 64'd1 << idx;
        wm = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        case (op)
            0: r = a & ~m;
            1: r = a | m;
            2: r = a ^ m;
            default: r = {63'd0, a[idx]};
        endcase
        return r & wm;
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        instr0 = '0; a0 = '0; b0 = '0;
        instr1 = '0; a1 = '0; b1 = '0;
        repeat (3) @(negedge clk);
        // R10: reset value of the registered copy
        chk("R10", "reset sel", sel1, 0);
        chk("R10", "reset class", cls1, 0);
        chk("R10", "reset valid", val1, 0);
        chk("R10", "reset result", res1, 0);
        rst = 1'b0;

        // 32-bit sweep: all ops, both forms, every index
        for (int op = 0; op < 4; op++) begin
            for (int form = 0; form < 2; form++) begin
                for (int idx = 0; idx < 32; idx++) begin
                    for (int rep = 0; rep < 3; rep++) begin
                        logic [63:0] a;
                        a = {$urandom, $urandom};
                        @(negedge clk);
                        // R6: register form ignores bit 25; immediate uses 0
                        instr0 = enc(op, form == 1, (form == 0) ? 1'($urandom) : 1'b0,
                                     15'($urandom));
                        a0 = a[31:0];
                        b0 = ($urandom & ~32'd31) | 32'(idx);
                        #1;
                        chk(req_of(op), "u0 result", res0, exp_res(op, a, idx, 32));
                        chk("R6", "u0 select", sel0, exp_sel(op));
                        chk("R7", "u0 class", cls0, 4'b0001);
                        chk("R7", "u0 valid", val0, 1);
                        chk("R5", "u0 sub_arith", ar0, (op == 3) ? 1 : 0);
                    end
                end
            end
        end

        // R1: a random high part of B never disturbs the index decode
        @(negedge clk);
        instr0 = enc(1, 1'b0, 1'b0, 15'd0);
        a0 = 32'd0;
        b0 = 32'hFFFF_FFE0 | 32'd7;
        #1;
        chk("R1", "mask from low bits", res0, 64'h80);

        // R8: ordinary instructions pass funct3, nothing active
        @(negedge clk);
        instr0 = {7'b0000000, 5'd3, 5'd2, 3'b000, 5'd1, 7'b0110011}; // add
        a0 = 32'hFFFF_FFFF; b0 = 32'd4;
        #1;
        chk("R8", "add select", sel0, 3'b000);
        chk("R8", "add class", cls0, 0);
        chk("R8", "add valid", val0, 0);
        chk("R8", "add result", res0, 0);
        @(negedge clk);
        instr0 = {7'b0100000, 5'd3, 5'd2, 3'b101, 5'd1, 7'b0110011}; // sra
        #1;
        chk("R8", "sra select", sel0, 3'b101);
        chk("R8", "sra class", cls0, 0);
        chk("R8", "sra sub_arith", ar0, 0);
        @(negedge clk);
        instr0 = {7'b0100100, 5'd3, 5'd2, 3'b101, 5'd1, 7'b0110111}; // wrong opcode
        #1;
        chk("R8", "foreign opcode valid", val0, 0);
        chk("R8", "foreign opcode select", sel0, 3'b101);

        // R9: 32-bit immediate with bit 25 set is rejected
        for (int op = 0; op < 4; op++) begin
            @(negedge clk);
            instr0 = enc(op, 1'b1, 1'b1, 15'($urandom));
            a0 = 32'hFFFF_FFFF; b0 = 32'd0;
            #1;
            chk("R9", "bit25 valid", val0, 0);
            chk("R9", "bit25 class", cls0, 0);
            chk("R9", "bit25 select", sel0, (op == 3) ? 3'b101 : 3'b001);
            chk("R9", "bit25 result", res0, 0);
        end

        // 64-bit registered sweep
        for (int op = 0; op < 4; op++) begin
            for (int form = 0; form < 2; form++) begin
                for (int idx = 0; idx < 64; idx++) begin
                    for (int rep = 0; rep < 3; rep++) begin
                        logic [63:0] a;
                        bit b25;
                        a = {$urandom, $urandom};
                        b25 = (form == 1) ? 1'(idx >> 5) : 1'($urandom);
                        @(negedge clk);
                        instr1 = enc(op, form == 1, b25, 15'($urandom));
                        @(negedge clk);
                        a1 = a;
                        b1 = ({$urandom, $urandom} & ~64'd63) | 64'(idx);
                        #1;
                        chk(req_of(op), "u1 result", res1, exp_res(op, a, idx, 64));
                        chk("R10", "u1 select", sel1, exp_sel(op));
                        chk("R6", "u1 class", cls1, 4'b0001);
                        chk("R5", "u1 sub_arith", ar1, (op == 3) ? 1 : 0);
                    end
                end
            end
        end

        // R10: one clock of latency
        @(negedge clk);
        instr1 = enc(1, 1'b0, 1'b0, 15'd0);
        @(negedge clk);
        instr1 = enc(2, 1'b0, 1'b0, 15'd0);
        #1;
        chk("R10", "latency old select", sel1, 3'b110);
        @(negedge clk);
        #1;
        chk("R10", "latency new select", sel1, 3'b100);

        // R11: flush clears, also with stall
        @(negedge clk);
        instr1 = enc(3, 1'b0, 1'b0, 15'd0);
        @(negedge clk);
        flush1 = 1'b1;
        @(negedge clk);
        flush1 = 1'b0;
        a1 = '1; b1 = 64'd5;
        #1;
        chk("R11", "flush select", sel1, 0);
        chk("R11", "flush valid", val1, 0);
        chk("R11", "flush result", res1, 0);
        @(negedge clk);
        #1;
        chk("R11", "refill valid", val1, 1);
        flush1 = 1'b1; stall1 = 1'b1;
        @(negedge clk);
        flush1 = 1'b0; stall1 = 1'b0;
        #1;
        chk("R11", "flush over stall class", cls1, 0);
        chk("R11", "flush over stall arith", ar1, 0);

        // R12: stall holds
        @(negedge clk);
        instr1 = enc(1, 1'b1, 1'b0, 15'd0);
        @(negedge clk);
        stall1 = 1'b1;
        instr1 = {7'b0000000, 5'd3, 5'd2, 3'b000, 5'd1, 7'b0110011};
        @(negedge clk);
        @(negedge clk);
        a1 = 64'd0; b1 = 64'd40;
        #1;
        chk("R12", "stall select", sel1, 3'b110);
        chk("R12", "stall class", cls1, 4'b0001);
        chk("R12", "stall result", res1, 64'd1 << 40);
        stall1 = 1'b0;
        @(negedge clk);
        #1;
        chk("R12", "release select", sel1, 3'b000);
        chk("R12", "release valid", val1, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule